// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block sits at the home node of a distributed shared-memory machine with `NODES` processing nodes. For every memory block homed here, it keeps a record of which nodes hold a copy and whether one node holds it modified. Read-miss and write-miss requests arrive as messages on a valid/ready port. The controller answers each one with one of three things: a data reply served from home memory, a reply that names the current dirty holder so the data can be fetched from that node, or a write grant. Before a write grant, it sends invalidations to every other holder and waits until each one has been acknowledged.

Two storage variants are selected by the `LIMITED` parameter. The full-map variant keeps one presence bit per node. The limited variant keeps two encoded node pointers per block, each with its own empty flag. In both variants a per-block modified bit separates the three block conditions: uncached, clean-shared and dirty. Only one transaction is in flight at a time, and request intake is closed until it has finished. Memory contents and the network fabric lie outside the block.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is uncached, `req_ready` is high and `rsp_valid`, `inv_valid` and `ack_ready` are low. The first read of any block is answered with a memory-data reply.
- R2: A read miss to a block that is not dirty is answered with `rsp_kind` 0 (data from home memory), and the requester is added to the block's holders.
- R3: A read miss to a dirty block is answered with `rsp_kind` 1, with `rsp_owner` carrying the dirty holder's node number. The block then becomes clean, held by the former owner and by the requester.
- R4: A write request sends one invalidation to each holder other than the requester. They go out one per `inv_valid`/`inv_ready` handshake, in ascending node order, carrying the block number on `inv_block`. No invalidation is ever sent to the requester.
- R5: The acknowledgement count equals the number of invalidations sent. `rsp_kind` 2 (write grant) appears only after that many acknowledgements have been taken, and `ack_ready` is high only while some remain owed. If there are no other holders, the grant follows with no invalidation.
- R6: After a write grant the block is dirty and held by the writer alone.
- R7: From the cycle a request is accepted until its response handshake completes, `req_ready` stays low.
- R8: While `rsp_valid` or `inv_valid` is high and not accepted, the corresponding output fields hold their values.
- R9: A read from a node that already holds the block is answered with `rsp_kind` 0 and leaves the block unchanged.
- R10: In limited mode, the first two readers are recorded in arrival order in pointer 0 and pointer 1. A read of a dirty block leaves the former owner in pointer 0 and the reader in pointer 1.
- R11: In limited mode, a read miss to a clean block whose two pointers are both in use invalidates the node in pointer 0 and waits for its acknowledgement. It then puts the requester in pointer 0 and answers with `rsp_kind` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request message present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write miss, 0 = read miss |
| req_node | input | NW | Requesting node |
| req_block | input | BW | Block index within this home |
| rsp_valid | output | 1 | Response message present |
| rsp_ready | input | 1 | Response accepted |
| rsp_kind | output | 2 | 0 data from memory, 1 fetch from owner, 2 write grant |
| rsp_node | output | NW | Destination node (the requester) |
| rsp_owner | output | NW | Dirty holder, meaningful when `rsp_kind` is 1 |
| rsp_block | output | BW | Block of the response |
| inv_valid | output | 1 | Invalidation message present |
| inv_ready | input | 1 | Invalidation accepted |
| inv_node | output | NW | Node to invalidate |
| inv_block | output | BW | Block to invalidate |
| ack_valid | input | 1 | One invalidation acknowledgement |
| ack_ready | output | 1 | Acknowledgements are still owed |

## Verification
The hardest condition to reach is pointer overflow in limited mode. It needs a block to stay clean while two distinct readers land on it and a third, different reader then arrives. A write anywhere in that sequence collapses the block to a single holder. Directed sequences build this case on purpose, including the case where the block was first made dirty and then shared through an owner reply. Random traffic is confined to four blocks and favours reads, so clean blocks with two or more holders, and the multi-target invalidation bursts that follow them, occur often. Invalidation, acknowledgement and response handshakes are stalled at random so that the grant timing is tested against late acknowledgements.

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl #(
  parameter int NODES   = 4,
  parameter int BLOCKS  = 8,
  parameter int LIMITED = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [NW-1:0]        req_node,
  input  logic [BW-1:0]        req_block,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [1:0]           rsp_kind,
  output logic [NW-1:0]        rsp_node,
  output logic [NW-1:0]        rsp_owner,
  output logic [BW-1:0]        rsp_block,
  output logic                 inv_valid,
  input  logic                 inv_ready,
  output logic [NW-1:0]        inv_node,
  output logic [BW-1:0]        inv_block,
  input  logic                 ack_valid,
  output logic                 ack_ready
);
  localparam int NW = (NODES  > 1) ? $clog2(NODES)  : 1;
  localparam int BW = (BLOCKS > 1) ? $clog2(BLOCKS) : 1;
  localparam int CW = $clog2(NODES + 1);

  localparam logic [1:0] K_DATA  = 2'd0;
  localparam logic [1:0] K_OWNER = 2'd1;
  localparam logic [1:0] K_GRANT = 2'd2;

  localparam logic [1:0] OP_ADD  = 2'd0;
  localparam logic [1:0] OP_PAIR = 2'd1;
  localparam logic [1:0] OP_ONLY = 2'd2;
  localparam logic [1:0] OP_REPL = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_COLLECT, S_RESP} st_t;

  function automatic logic [NODES-1:0] bit_of(input logic [NW-1:0] n);
    bit_of = '0;
    bit_of[n] = 1'b1;
  endfunction

  function automatic logic [NW-1:0] low_idx(input logic [NODES-1:0] v);
    low_idx = '0;
    for (int i = NODES - 1; i >= 0; i--)
      if (v[i]) low_idx = NW'(i);
  endfunction

  function automatic logic [CW-1:0] popc(input logic [NODES-1:0] v);
    popc = '0;
    for (int i = 0; i < NODES; i++)
      popc = popc + CW'(v[i]);
  endfunction

  st_t              st;
  logic [NW-1:0]    cur_node, owner_q;
  logic [BW-1:0]    cur_blk;
  logic             cur_wr;
  logic [NODES-1:0] pend;
  logic [CW-1:0]    cnt;
  logic [1:0]       kind_q;
  logic             mod_q [BLOCKS];

  logic [BW-1:0]    sel_blk;
  logic [NODES-1:0] cur_vec, others;
  logic [NW-1:0]    cur_own;
  logic             cur_full, hit, is_mod, evict, acc, done;
  logic             dir_we, mod_we, mod_d;
  logic [1:0]       dir_op;
  logic [NW-1:0]    dir_a, dir_b;

  assign sel_blk = (st == S_IDLE) ? req_block : cur_blk;
  assign acc     = req_valid && (st == S_IDLE);
  assign hit     = cur_vec[req_node];
  assign is_mod  = mod_q[sel_blk];
  assign others  = cur_vec & ~bit_of(req_node);
  assign evict   = (LIMITED != 0) && !req_write && !hit && !is_mod && cur_full;
  assign done    = (st == S_COLLECT) && (pend == '0) && (cnt == '0);

  generate
    if (LIMITED != 0) begin : g_ptr
      logic [NW-1:0] p0 [BLOCKS];
      logic [NW-1:0] p1 [BLOCKS];
      logic          v0 [BLOCKS];
      logic          v1 [BLOCKS];
      assign cur_vec  = (v0[sel_blk] ? bit_of(p0[sel_blk]) : '0) |
                        (v1[sel_blk] ? bit_of(p1[sel_blk]) : '0);
      assign cur_own  = p0[sel_blk];
      assign cur_full = v0[sel_blk] && v1[sel_blk];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < BLOCKS; i++) begin
            p0[i] <= '0; p1[i] <= '0; v0[i] <= 1'b0; v1[i] <= 1'b0;
          end
        end else if (dir_we) begin
          case (dir_op)
            OP_ADD:
              if (!v0[sel_blk]) begin p0[sel_blk] <= dir_a; v0[sel_blk] <= 1'b1; end
              else              begin p1[sel_blk] <= dir_a; v1[sel_blk] <= 1'b1; end
            OP_PAIR: begin
              p0[sel_blk] <= dir_b; v0[sel_blk] <= 1'b1;
              p1[sel_blk] <= dir_a; v1[sel_blk] <= 1'b1;
            end
            OP_ONLY: begin
              p0[sel_blk] <= dir_a; v0[sel_blk] <= 1'b1; v1[sel_blk] <= 1'b0;
            end
            default: p0[sel_blk] <= dir_a;
          endcase
        end
      end
    end else begin : g_map
      logic [NODES-1:0] pres [BLOCKS];
      assign cur_vec  = pres[sel_blk];
      assign cur_own  = low_idx(pres[sel_blk]);
      assign cur_full = 1'b0;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < BLOCKS; i++) pres[i] <= '0;
        end else if (dir_we) begin
          case (dir_op)
            OP_ADD:  pres[sel_blk] <= pres[sel_blk] | bit_of(dir_a);
            OP_PAIR: pres[sel_blk] <= bit_of(dir_a) | bit_of(dir_b);
            OP_ONLY: pres[sel_blk] <= bit_of(dir_a);
            default: pres[sel_blk] <= (pres[sel_blk] & ~bit_of(dir_b)) | bit_of(dir_a);
          endcase
        end
      end
    end
  endgenerate

  always_comb begin
    dir_we = 1'b0;
    dir_op = OP_ADD;
    dir_a  = req_node;
    dir_b  = cur_own;
    mod_we = 1'b0;
    mod_d  = 1'b0;
    if (acc) begin
      if (req_write) begin
        if (others == '0) begin
          dir_we = 1'b1; dir_op = OP_ONLY; mod_we = 1'b1; mod_d = 1'b1;
        end
      end else if (!hit) begin
        if (is_mod) begin
          dir_we = 1'b1; dir_op = OP_PAIR; mod_we = 1'b1;
        end else if (!evict) begin
          dir_we = 1'b1;
        end
      end
    end else if (done) begin
      dir_we = 1'b1;
      dir_a  = cur_node;
      if (cur_wr) begin
        dir_op = OP_ONLY; mod_we = 1'b1; mod_d = 1'b1;
      end else begin
        dir_op = OP_REPL;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BLOCKS; i++) mod_q[i] <= 1'b0;
    end else if (mod_we) begin
      mod_q[sel_blk] <= mod_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_node <= '0;
      cur_blk  <= '0;
      cur_wr   <= 1'b0;
      owner_q  <= '0;
      pend     <= '0;
      cnt      <= '0;
      kind_q   <= K_DATA;
    end else begin
      case (st)
        S_IDLE:
          if (acc) begin
            cur_node <= req_node;
            cur_blk  <= req_block;
            cur_wr   <= req_write;
            owner_q  <= cur_own;
            if (req_write) begin
              kind_q <= K_GRANT;
              if (others == '0) st <= S_RESP;
              else begin
                pend <= others;
                cnt  <= popc(others);
                st   <= S_COLLECT;
              end
            end else if (!hit && is_mod) begin
              kind_q <= K_OWNER;
              st     <= S_RESP;
            end else if (evict) begin
              kind_q <= K_DATA;
              pend   <= bit_of(cur_own);
              cnt    <= CW'(1);
              st     <= S_COLLECT;
            end else begin
              kind_q <= K_DATA;
              st     <= S_RESP;
            end
          end
        S_COLLECT: begin
          if (inv_valid && inv_ready) pend <= pend & ~bit_of(inv_node);
          if (ack_valid && ack_ready) cnt <= cnt - CW'(1);
          if (done) st <= S_RESP;
        end
        default:
          if (rsp_ready) st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_RESP);
  assign rsp_kind  = kind_q;
  assign rsp_node  = cur_node;
  assign rsp_owner = owner_q;
  assign rsp_block = cur_blk;
  assign inv_valid = (st == S_COLLECT) && (pend != '0);
  assign inv_node  = low_idx(pend);
  assign inv_block = cur_blk;
  assign ack_ready = (st == S_COLLECT) && (cnt != '0);
endmodule

// File: rtl/dir_home_chk.sv
module dir_home_chk #(
  parameter int NW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [1:0]    rsp_kind,
  input logic [NW-1:0] rsp_node,
  input logic [NW-1:0] rsp_owner,
  input logic          inv_valid,
  input logic          inv_ready,
  input logic [NW-1:0] inv_node,
  input logic          ack_ready,
  input logic [NW-1:0] held_node
);
  a_r7_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || inv_valid || ack_ready) |-> !req_ready);

  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_kind) &&
                                   $stable(rsp_node) && $stable(rsp_owner)));

  a_r8_inv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !inv_ready) |=> (inv_valid && $stable(inv_node)));

  a_r4_no_self_inval: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> (inv_node != held_node));

  a_r5_grant_after_acks: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!ack_ready && !inv_valid));

  a_r2_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_kind != 2'd3));
endmodule

bind dir_home_ctrl dir_home_chk #(.NW(NW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_kind(rsp_kind), .rsp_node(rsp_node),
  .rsp_owner(rsp_owner), .inv_valid(inv_valid), .inv_ready(inv_ready),
  .inv_node(inv_node), .ack_ready(ack_ready), .held_node(cur_node)
);

// File: tb/test_dir_home_ctrl.sv
`timescale 1ns/1ps
module test_dir_home_ctrl;
  localparam int NODES = 4;
  localparam int BLOCKS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       req_valid [2], req_write [2], rsp_ready [2], inv_ready [2], ack_valid [2];
  logic [1:0] req_node [2];
  logic [2:0] req_block [2];
  logic       req_ready [2], rsp_valid [2], inv_valid [2], ack_ready [2];
  logic [1:0] rsp_kind [2], rsp_node [2], rsp_owner [2], inv_node [2];
  logic [2:0] rsp_block [2], inv_block [2];

  for (genvar g = 0; g < 2; g++) begin : g_dut
    if (g == 0) begin : g_full
      dir_home_ctrl #(.NODES(NODES), .BLOCKS(BLOCKS), .LIMITED(0)) i_dir_home_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid[g]), .req_ready(req_ready[g]), .req_write(req_write[g]),
        .req_node(req_node[g]), .req_block(req_block[g]),
        .rsp_valid(rsp_valid[g]), .rsp_ready(rsp_ready[g]), .rsp_kind(rsp_kind[g]),
        .rsp_node(rsp_node[g]), .rsp_owner(rsp_owner[g]), .rsp_block(rsp_block[g]),
        .inv_valid(inv_valid[g]), .inv_ready(inv_ready[g]), .inv_node(inv_node[g]),
        .inv_block(inv_block[g]), .ack_valid(ack_valid[g]), .ack_ready(ack_ready[g]));
    end else begin : g_lim
      dir_home_ctrl #(.NODES(NODES), .BLOCKS(BLOCKS), .LIMITED(1)) i_dir_home_ctrl_lim (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid[g]), .req_ready(req_ready[g]), .req_write(req_write[g]),
        .req_node(req_node[g]), .req_block(req_block[g]),
        .rsp_valid(rsp_valid[g]), .rsp_ready(rsp_ready[g]), .rsp_kind(rsp_kind[g]),
        .rsp_node(rsp_node[g]), .rsp_owner(rsp_owner[g]), .rsp_block(rsp_block[g]),
        .inv_valid(inv_valid[g]), .inv_ready(inv_ready[g]), .inv_node(inv_node[g]),
        .inv_block(inv_block[g]), .ack_valid(ack_valid[g]), .ack_ready(ack_ready[g]));
    end
  end

  int tests = 0;
  int fails = 0;

  logic [3:0] mvec [2][BLOCKS];
  logic       mmod [2][BLOCKS];
  int         mp0  [2][BLOCKS];
  int         mp1  [2][BLOCKS];
  logic       mv0  [2][BLOCKS];
  logic       mv1  [2][BLOCKS];

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] holders(int m, int b);
    if (m == 0) return mvec[m][b];
    return (mv0[m][b] ? 4'(1 << mp0[m][b]) : 4'd0) | (mv1[m][b] ? 4'(1 << mp1[m][b]) : 4'd0);
  endfunction

  function automatic int lowest(logic [3:0] v);
    for (int i = 0; i < NODES; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic txn(int m, bit w, int n, int b, string tag);
    logic [3:0] vec, oth;
    int exp_inv [4];
    int ninv = 0;
    int ekind, eown = 0;
    string itag = "R4";
    vec = holders(m, b);
    if (w) begin
      oth = vec & ~4'(1 << n);
      for (int i = 0; i < NODES; i++) if (oth[i]) begin exp_inv[ninv] = i; ninv++; end
      ekind = 2;
      mvec[m][b] = 4'(1 << n); mp0[m][b] = n; mv0[m][b] = 1; mv1[m][b] = 0;
      mmod[m][b] = 1;
    end else if (vec[n]) begin
      ekind = 0;
    end else if (mmod[m][b]) begin
      ekind = 1; eown = lowest(vec);
      mvec[m][b] = vec | 4'(1 << n); mp1[m][b] = n; mv1[m][b] = 1;
      mmod[m][b] = 0;
    end else if (m == 1 && mv0[m][b] && mv1[m][b]) begin
      ekind = 0; exp_inv[0] = mp0[m][b]; ninv = 1; itag = "R11";
      mp0[m][b] = n;
    end else begin
      ekind = 0;
      mvec[m][b] = vec | 4'(1 << n);
      if (!mv0[m][b]) begin mp0[m][b] = n; mv0[m][b] = 1; end
      else begin mp1[m][b] = n; mv1[m][b] = 1; end
    end

    @(negedge clk);
    chk("R7", int'(req_ready[m]), 1);
    req_valid[m] = 1; req_write[m] = w; req_node[m] = 2'(n); req_block[m] = 3'(b);
    @(posedge clk);
    @(negedge clk);
    req_valid[m] = 0;

    for (int i = 0; i < ninv; i++) begin
      for (int t = 0; t < 20 && !inv_valid[m]; t++) @(negedge clk);
      chk(itag, int'(inv_valid[m]), 1);
      chk(itag, int'(inv_node[m]), exp_inv[i]);
      chk("R4", int'(inv_block[m]), b);
      chk("R5", int'(rsp_valid[m]), 0);
      repeat ($urandom_range(0, 2)) @(negedge clk);
      inv_ready[m] = 1;
      @(posedge clk);
      @(negedge clk);
      inv_ready[m] = 0;
    end
    chk("R4", int'(inv_valid[m]), 0);

    for (int i = 0; i < ninv; i++) begin
      repeat ($urandom_range(0, 2)) begin
        @(negedge clk);
        chk("R5", int'(rsp_valid[m]), 0);
      end
      chk("R5", int'(ack_ready[m]), 1);
      chk("R5", int'(rsp_valid[m]), 0);
      ack_valid[m] = 1;
      @(posedge clk);
      @(negedge clk);
      ack_valid[m] = 0;
    end
    chk("R5", int'(ack_ready[m]), 0);

    for (int t = 0; t < 5 && !rsp_valid[m]; t++) @(negedge clk);
    chk(tag, int'(rsp_valid[m]), 1);
    chk(tag, int'(rsp_kind[m]), ekind);
    chk(tag, int'(rsp_node[m]), n);
    chk(tag, int'(rsp_block[m]), b);
    if (ekind == 1) chk(tag, int'(rsp_owner[m]), eown);
    repeat ($urandom_range(0, 2)) begin
      @(negedge clk);
      chk("R7", int'(req_ready[m]), 0);
      chk("R8", int'(rsp_kind[m]), ekind);
    end
    rsp_ready[m] = 1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready[m] = 0;
    chk("R7", int'(req_ready[m]), 1);
    chk("R7", int'(rsp_valid[m]), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int m = 0; m < 2; m++) begin
      req_valid[m] = 0; req_write[m] = 0; req_node[m] = 0; req_block[m] = 0;
      rsp_ready[m] = 0; inv_ready[m] = 0; ack_valid[m] = 0;
      for (int b = 0; b < BLOCKS; b++) begin
        mvec[m][b] = 0; mmod[m][b] = 0; mp0[m][b] = 0; mp1[m][b] = 0;
        mv0[m][b] = 0; mv1[m][b] = 0;
      end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      chk("R1", int'(req_ready[m]), 1);
      chk("R1", int'(rsp_valid[m]), 0);
      chk("R1", int'(inv_valid[m]), 0);
      chk("R1", int'(ack_ready[m]), 0);
    end

    txn(0, 0, 1, 0, "R1");
    txn(0, 0, 2, 0, "R2");
    txn(0, 1, 3, 0, "R5");
    txn(0, 0, 0, 0, "R6");
    txn(0, 0, 1, 0, "R3");
    txn(0, 1, 0, 0, "R3");
    txn(0, 1, 0, 0, "R5");
    txn(0, 0, 0, 0, "R9");
    txn(0, 1, 2, 0, "R9");
    txn(0, 1, 1, 5, "R5");

    txn(1, 0, 0, 1, "R1");
    txn(1, 0, 1, 1, "R10");
    txn(1, 0, 1, 1, "R9");
    txn(1, 0, 2, 1, "R11");
    txn(1, 0, 3, 1, "R11");
    txn(1, 1, 0, 1, "R6");
    txn(1, 0, 2, 1, "R10");
    txn(1, 0, 3, 1, "R11");
    txn(1, 1, 1, 1, "R4");

    for (int k = 0; k < 400; k++) begin
      int m = k % 2;
      bit w = ($urandom_range(0, 99) < 25);
      txn(m, w, $urandom_range(0, 3), $urandom_range(0, 3), w ? "R6" : "R2");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule